// File: doc/BRIEF.md
# Reset-Time Debug Mode Strap Selector

This block watches a handful of debug pins on the system clock while the chip comes out of reset, and settles which debug mode is active for the rest of the session. There are four results: boundary-scan only (the default), background debug, or an auxiliary trace port in either full or reduced width. The choice depends on pin levels measured against two reset edges: the release of the device reset (power-on or hard reset) and, for background debug, the later release of the system reset. The stability windows are counted in clock cycles.

Once the decision is final, the block gives a one-cycle valid strobe and then holds the one-hot mode flags, the width selection, the resulting trace port widths, the background-debug clock select and a sticky setup-violation flag. These outputs do not change until the next device reset. Device reset means `por_n` or `hrst_n` is low. It is sampled on the clock and returns every output to the boundary-scan-only default. All pins are taken as already synchronous to `clk`.

Top module: `dbg_mode_strap`

## Requirements
- R1: While `por_n` or `hrst_n` is low, the block reports boundary-scan only in the cycle that follows. That state is `mode_jtag`=1, `mode_bdm`=0, `mode_trace`=0, `port_full`=0, both widths 0, `bdm_clk_sel`=0, `setup_viol`=0 and `mode_valid`=0.
- R2: The trace path is taken only when `tpen` is low in the first clock where both device resets are high. Its decision is made in the first later clock where `tpen` is high.
- R3: On the trace path, trace mode is chosen only if `evt` was low and both `evt` and `ddat` held one level for at least SETUP_CLKS (4) consecutive clocks with `tpen` low, ending just before the `tpen` rise. With `evt` high over a long enough window, the result is boundary-scan only and no violation is flagged.
- R4: In trace mode, `ddat` high selects full width: `port_full`=1, `aux_in_w`=2, `aux_out_w`=8. `ddat` low selects reduced width: `port_full`=0, `aux_in_w`=1, `aux_out_w`=2. In the other modes both widths read 0.
- R5: On the trace path, a steady window shorter than SETUP_CLKS gives boundary-scan only and sets `setup_viol`. That flag stays set until the next device reset.
- R6: When `tpen` is high at device reset release, the block waits for a rising edge of `srst_n`. If `dck` is high in that same clock, background debug (`mode_bdm`=1) follows. If `dck` is low, boundary-scan only is decided in that clock.
- R7: The background-debug clock select `bdm_clk_sel` takes the level of `ddat` in the BDM_WIN-th (8th) clock after the `srst_n` rising-edge clock. No decision is reported before that clock.
- R8: On the trace path, `dck` and `srst_n` have no effect: the test-port path takes priority over background debug.
- R9: `mode_valid` is high for exactly one cycle, in the cycle after the decision clock.
- R10: After the decision, the mode flags, `port_full`, `bdm_clk_sel` and `setup_viol` stay constant whatever `srst_n`, `tpen`, `evt`, `dck` and `ddat` do, until the next device reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's registers |
| por_n | input | 1 | Power-on reset, active low |
| hrst_n | input | 1 | Hard reset, active low |
| srst_n | input | 1 | System reset, active low |
| tpen | input | 1 | Test-port enable/reset pin |
| evt | input | 1 | Event pin |
| dck | input | 1 | Debug clock pin |
| ddat | input | 1 | Debug data / port-width pin |
| mode_jtag | output | 1 | Boundary-scan-only mode flag |
| mode_bdm | output | 1 | Background debug mode flag |
| mode_trace | output | 1 | Auxiliary trace port mode flag |
| port_full | output | 1 | Full-width trace port selected |
| aux_in_w | output | 2 | Trace input stream width in bits |
| aux_out_w | output | 4 | Trace output stream width in bits |
| bdm_clk_sel | output | 1 | Background debug clock mode select |
| setup_viol | output | 1 | Sticky flag: trace setup window too short |
| mode_valid | output | 1 | One-cycle strobe when the mode is final |

## Verification
The bench targets the setup-window boundary with exactly three and exactly four steady clocks, and with a level change in the middle of the window. A design that counted the window from reset release, or that ignored a late change, would pick trace mode where it should flag a violation. Background debug is probed in the clock before the 8th sample clock, with `ddat` toggling over the whole window. A design that sampled early or late would latch the wrong clock select or raise the valid strobe too soon. Trace trials raise `srst_n` with `dck` high before `tpen` rises, which catches a design that lets background debug override the test port. After each decision, every pin is toggled to expose outputs that are not truly latched.

// File: rtl/dbg_strap_pkg.sv
package dbg_strap_pkg;

  typedef enum logic [2:0] {
    ST_RESET,
    ST_TRACE_WAIT,
    ST_BDM_WAIT,
    ST_BDM_SAMPLE,
    ST_DONE
  } strap_st_e;

  typedef enum logic [1:0] {
    MD_JTAG  = 2'd0,
    MD_BDM   = 2'd1,
    MD_TRACE = 2'd2
  } dbg_mode_e;

endpackage

// File: rtl/dbg_pin_sampler.sv
module dbg_pin_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic ddat,
  input  logic srst_n,
  output logic evt_q,
  output logic ddat_q,
  output logic lvl_same,
  output logic srst_rise
);

  logic srst_q;

  // Previous-cycle copies of the strap pins; enable is always on.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= 1'b0;
      ddat_q <= 1'b0;
      srst_q <= 1'b1;
    end else begin
      evt_q  <= evt;
      ddat_q <= ddat;
      srst_q <= srst_n;
    end
  end

  assign lvl_same  = (evt == evt_q) && (ddat == ddat_q);
  assign srst_rise = srst_n && !srst_q;

endmodule

// File: rtl/dbg_hold_counter.sv
module dbg_hold_counter #(
  parameter int MAXC = 8,
  localparam int CW  = $clog2(MAXC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load1,
  input  logic          inc,
  output logic [CW-1:0] cnt
);

  logic [CW-1:0] cnt_n;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr || load1 || (inc && (cnt != CW'(MAXC)));
    if (clr)        cnt_n = '0;
    else if (load1) cnt_n = CW'(1);
    else            cnt_n = cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_n;
  end

endmodule

// File: rtl/dbg_width_map.sv
module dbg_width_map
  import dbg_strap_pkg::*;
#(
  parameter int FULL_IN_W  = 2,
  parameter int FULL_OUT_W = 8,
  parameter int RED_IN_W   = 1,
  parameter int RED_OUT_W  = 2,
  localparam int IN_WW     = $clog2(FULL_IN_W + 1),
  localparam int OUT_WW    = $clog2(FULL_OUT_W + 1)
) (
  input  dbg_mode_e           mode,
  input  logic                full,
  output logic [IN_WW-1:0]    in_w,
  output logic [OUT_WW-1:0]   out_w
);

  always_comb begin
    in_w  = '0;
    out_w = '0;
    if (mode == MD_TRACE) begin
      in_w  = full ? IN_WW'(FULL_IN_W)   : IN_WW'(RED_IN_W);
      out_w = full ? OUT_WW'(FULL_OUT_W) : OUT_WW'(RED_OUT_W);
    end
  end

endmodule

// File: rtl/dbg_mode_strap.sv
module dbg_mode_strap
  import dbg_strap_pkg::*;
#(
  parameter int SETUP_CLKS = 4,
  parameter int BDM_WIN    = 8,
  parameter int FULL_IN_W  = 2,
  parameter int FULL_OUT_W = 8,
  parameter int RED_IN_W   = 1,
  parameter int RED_OUT_W  = 2,
  localparam int IN_WW     = $clog2(FULL_IN_W + 1),
  localparam int OUT_WW    = $clog2(FULL_OUT_W + 1),
  localparam int MAXC      = (SETUP_CLKS > BDM_WIN) ? SETUP_CLKS : BDM_WIN,
  localparam int CW        = $clog2(MAXC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              hrst_n,
  input  logic              srst_n,
  input  logic              tpen,
  input  logic              evt,
  input  logic              dck,
  input  logic              ddat,
  output logic              mode_jtag,
  output logic              mode_bdm,
  output logic              mode_trace,
  output logic              port_full,
  output logic [IN_WW-1:0]  aux_in_w,
  output logic [OUT_WW-1:0] aux_out_w,
  output logic              bdm_clk_sel,
  output logic              setup_viol,
  output logic              mode_valid
);

  logic          dev_rst;
  logic          evt_q, ddat_q, lvl_same, srst_rise;
  logic          cnt_clr, cnt_load1, cnt_inc;
  logic [CW-1:0] cnt;

  strap_st_e state_q, state_n;
  dbg_mode_e mode_q, mode_n;
  logic      full_q, full_n, bclk_q, bclk_n, viol_q, viol_n, valid_q, valid_n;

  assign dev_rst = !por_n || !hrst_n;

  dbg_pin_sampler u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt),
    .ddat      (ddat),
    .srst_n    (srst_n),
    .evt_q     (evt_q),
    .ddat_q    (ddat_q),
    .lvl_same  (lvl_same),
    .srst_rise (srst_rise)
  );

  dbg_hold_counter #(.MAXC(MAXC)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .load1 (cnt_load1),
    .inc   (cnt_inc),
    .cnt   (cnt)
  );

  // Next-state decode of the strap sequence.
  always_comb begin
    state_n   = state_q;
    mode_n    = mode_q;
    full_n    = full_q;
    bclk_n    = bclk_q;
    viol_n    = viol_q;
    valid_n   = 1'b0;
    cnt_clr   = 1'b0;
    cnt_load1 = 1'b0;
    cnt_inc   = 1'b0;
    if (dev_rst) begin
      state_n = ST_RESET;
      mode_n  = MD_JTAG;
      full_n  = 1'b0;
      bclk_n  = 1'b0;
      viol_n  = 1'b0;
      cnt_clr = 1'b1;
    end else begin
      unique case (state_q)
        ST_RESET: begin
          cnt_clr = 1'b1;
          state_n = tpen ? ST_BDM_WAIT : ST_TRACE_WAIT;
        end
        ST_TRACE_WAIT: begin
          if (tpen) begin
            state_n = ST_DONE;
            valid_n = 1'b1;
            mode_n  = MD_JTAG;
            if (cnt >= CW'(SETUP_CLKS)) begin
              if (!evt_q) begin
                mode_n = MD_TRACE;
                full_n = ddat_q;
              end
            end else begin
              viol_n = 1'b1;
            end
          end else if ((cnt == '0) || lvl_same) begin
            cnt_inc = 1'b1;
          end else begin
            cnt_load1 = 1'b1;
          end
        end
        ST_BDM_WAIT: begin
          if (srst_rise) begin
            if (dck) begin
              state_n = ST_BDM_SAMPLE;
              cnt_clr = 1'b1;
            end else begin
              state_n = ST_DONE;
              valid_n = 1'b1;
              mode_n  = MD_JTAG;
            end
          end
        end
        ST_BDM_SAMPLE: begin
          if (cnt == CW'(BDM_WIN - 1)) begin
            state_n = ST_DONE;
            valid_n = 1'b1;
            mode_n  = MD_BDM;
            bclk_n  = ddat;
          end else begin
            cnt_inc = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RESET;
      mode_q  <= MD_JTAG;
      full_q  <= 1'b0;
      bclk_q  <= 1'b0;
      viol_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_n;
      mode_q  <= mode_n;
      full_q  <= full_n;
      bclk_q  <= bclk_n;
      viol_q  <= viol_n;
      valid_q <= valid_n;
    end
  end

  dbg_width_map #(
    .FULL_IN_W  (FULL_IN_W),
    .FULL_OUT_W (FULL_OUT_W),
    .RED_IN_W   (RED_IN_W),
    .RED_OUT_W  (RED_OUT_W)
  ) u_width (
    .mode  (mode_q),
    .full  (full_q),
    .in_w  (aux_in_w),
    .out_w (aux_out_w)
  );

  assign mode_jtag   = (mode_q == MD_JTAG);
  assign mode_bdm    = (mode_q == MD_BDM);
  assign mode_trace  = (mode_q == MD_TRACE);
  assign port_full   = full_q;
  assign bdm_clk_sel = bclk_q;
  assign setup_viol  = viol_q;
  assign mode_valid  = valid_q;

  p_reset_default_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst |=> (mode_jtag && !setup_viol && !mode_valid && (aux_out_w == '0)));

  p_trace_on_tpen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_trace) |-> $past(tpen));

  p_width_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_trace && port_full) |->
      ((aux_in_w == IN_WW'(FULL_IN_W)) && (aux_out_w == OUT_WW'(FULL_OUT_W))));

  p_viol_jtag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    setup_viol |-> mode_jtag);

  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid |=> !mode_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_DONE) && !dev_rst) |=>
      $stable({mode_jtag, mode_bdm, mode_trace, port_full, bdm_clk_sel, setup_viol}));

endmodule

// File: tb/dbg_mode_strap_tb_top.sv
module dbg_mode_strap_tb_top;

  localparam int MJ = 0, MB = 1, MT = 2;

  logic clk = 1'b0;
  logic rst_n, por_n, hrst_n, srst_n, tpen, evt, dck, ddat;
  logic mode_jtag, mode_bdm, mode_trace, port_full, bdm_clk_sel, setup_viol, mode_valid;
  logic [1:0] aux_in_w;
  logic [3:0] aux_out_w;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dbg_mode_strap dut_i (
    .clk (clk), .rst_n (rst_n), .por_n (por_n), .hrst_n (hrst_n),
    .srst_n (srst_n), .tpen (tpen), .evt (evt), .dck (dck), .ddat (ddat),
    .mode_jtag (mode_jtag), .mode_bdm (mode_bdm), .mode_trace (mode_trace),
    .port_full (port_full), .aux_in_w (aux_in_w), .aux_out_w (aux_out_w),
    .bdm_clk_sel (bdm_clk_sel), .setup_viol (setup_viol), .mode_valid (mode_valid)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_in_w(input int m, input bit f);
    if (m != MT) return 0;
    return f ? 2 : 1;
  endfunction

  function automatic int exp_out_w(input int m, input bit f);
    if (m != MT) return 0;
    return f ? 8 : 2;
  endfunction

  task automatic check_out(input string req, input int m, input bit f, input bit bc,
                           input bit v, input bit vld);
    int act_m;
    act_m = mode_trace ? MT : (mode_bdm ? MB : MJ);
    chk(($countones({mode_jtag, mode_bdm, mode_trace}) == 1) && (act_m == m),
        req, "mode", act_m, m);
    chk(port_full == f, req, "port_full", int'(port_full), int'(f));
    chk(int'(aux_in_w) == exp_in_w(m, f), req, "aux_in_w", int'(aux_in_w), exp_in_w(m, f));
    chk(int'(aux_out_w) == exp_out_w(m, f), req, "aux_out_w", int'(aux_out_w), exp_out_w(m, f));
    chk(bdm_clk_sel == bc, req, "bdm_clk_sel", int'(bdm_clk_sel), int'(bc));
    chk(setup_viol == v, req, "setup_viol", int'(setup_viol), int'(v));
    chk(mode_valid == vld, req, "mode_valid", int'(mode_valid), int'(vld));
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic dev_reset(input bit use_hrst, input bit tp);
    por_n = use_hrst; hrst_n = !use_hrst; srst_n = 1'b0;
    tpen = tp; dck = 1'b0; evt = 1'b0; ddat = 1'b0;
    step(); step();
    check_out("R1", MJ, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  // Valid drops after one cycle, then pin activity must not move the result.
  task automatic hold_check(input int m, input bit f, input bit bc, input bit v);
    step();
    check_out("R9", m, f, bc, v, 1'b0);
    srst_n = 1'b0; tpen = !tpen; evt = !evt; dck = 1'b1; ddat = !ddat;
    step();
    srst_n = 1'b1; ddat = !ddat;
    step(); step();
    check_out("R10", m, f, bc, v, 1'b0);
  endtask

  task automatic trace_trial(input int len, input int chg, input bit e, input bit d, input bit with_bdm);
    int trailing, m;
    bit v, f;
    dev_reset(1'($urandom % 2), 1'b0);
    evt = e; ddat = !d; por_n = 1'b1; hrst_n = 1'b1;
    step();
    for (int i = 0; i < len; i++) begin
      evt = e;
      ddat = (i < chg) ? !d : d;
      if (with_bdm && i == 0) begin srst_n = 1'b1; dck = 1'b1; end
      step();
    end
    tpen = 1'b1;
    step();
    trailing = len - chg;
    if (trailing >= 4) begin
      v = 1'b0;
      m = e ? MJ : MT;
      f = e ? 1'b0 : d;
    end else begin
      v = 1'b1; m = MJ; f = 1'b0;
    end
    if (with_bdm) check_out("R8", m, f, 1'b0, v, 1'b1);
    else if (v) check_out("R5", m, f, 1'b0, v, 1'b1);
    else if (m == MT) check_out("R4", m, f, 1'b0, v, 1'b1);
    else check_out("R3", m, f, 1'b0, v, 1'b1);
    hold_check(m, f, 1'b0, v);
  endtask

  task automatic bdm_trial(input bit dk, input bit [7:0] pat);
    dev_reset(1'($urandom % 2), 1'b1);
    por_n = 1'b1; hrst_n = 1'b1;
    step(); step(); step();
    srst_n = 1'b1; dck = dk;
    step();
    if (!dk) begin
      check_out("R6", MJ, 1'b0, 1'b0, 1'b0, 1'b1);
      hold_check(MJ, 1'b0, 1'b0, 1'b0);
    end else begin
      for (int i = 0; i < 8; i++) begin
        ddat = pat[i];
        dck = 1'($urandom % 2);
        evt = 1'($urandom % 2);
        step();
        if (i < 7) chk(mode_valid == 1'b0 && mode_jtag == 1'b1, "R7", "early decision",
                       int'(mode_valid), 0);
      end
      check_out("R6", MB, 1'b0, pat[7], 1'b0, 1'b1);
      chk(bdm_clk_sel == pat[7], "R7", "clk select sample", int'(bdm_clk_sel), int'(pat[7]));
      hold_check(MB, 1'b0, pat[7], 1'b0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24680));
    rst_n = 1'b0; por_n = 1'b0; hrst_n = 1'b1; srst_n = 1'b0;
    tpen = 1'b0; evt = 1'b0; dck = 1'b0; ddat = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    step();
    check_out("R1", MJ, 1'b0, 1'b0, 1'b0, 1'b0);

    // Directed corners.
    trace_trial(4, 0, 1'b0, 1'b1, 1'b0);  // R4 full, exact window
    trace_trial(3, 0, 1'b0, 1'b1, 1'b0);  // R5 one short
    trace_trial(6, 3, 1'b0, 1'b0, 1'b0);  // R5 change leaves 3
    trace_trial(6, 2, 1'b0, 1'b0, 1'b0);  // R4 reduced, change leaves 4
    trace_trial(5, 0, 1'b1, 1'b1, 1'b0);  // R3 event high
    trace_trial(0, 0, 1'b0, 1'b1, 1'b0);  // R5 no window
    trace_trial(7, 0, 1'b0, 1'b1, 1'b1);  // R8 priority
    bdm_trial(1'b1, 8'b1000_0101);
    bdm_trial(1'b1, 8'b0111_1111);
    bdm_trial(1'b0, 8'h00);

    // Constrained random trials.
    for (int t = 0; t < 40; t++) begin
      if ($urandom % 3 == 0) begin
        bdm_trial(1'($urandom % 2), 8'($urandom));
      end else begin
        int len, chg;
        len = $urandom % 9;
        chg = (len == 0) ? 0 : int'($urandom % len);
        trace_trial(len, chg, 1'($urandom % 4 == 0), 1'($urandom % 2), 1'($urandom % 2));
      end
    end

    dev_reset(1'b1, 1'b0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule